// File: doc/BRIEF.md
# Segmented DAC Code Decoder

This block converts a 12-bit unsigned sample code into the switch controls of a segmented current-steering converter array. The code is split into three weight classes. The top five bits select how many of 31 large, equal units are on. The next four bits select how many of 15 mid-size units are on, each worth one sixteenth of a large unit. The bottom three bits drive three binary-weighted switches directly.

Every switch has a true control, which steers its unit to output node A, and a separately registered complement control, which steers the same unit to node B. The code is captured on a rising clock edge. All decoded controls are then registered together in a second stage, so every switch in the array changes on the same edge. A sleep input parks the whole array in its idle state.

Top module: `seg_dac_decoder`

## Requirements
- R1: While rst_ni is low, every true control (up_on_o, mid_on_o, lsb_on_o) is 0 and every complement control (up_off_o, mid_off_o, lsb_off_o) is all ones. The reset is asynchronous and active low.
- R2: up_on_o is a thermometer code. When the upper field code[11:7] has value N, exactly bits N-1..0 are set and all higher bits are clear.
- R3: mid_on_o is a thermometer code. When the middle field code[6:3] has value M, exactly bits M-1..0 are set and all higher bits are clear.
- R4: lsb_on_o equals code[2:0], with bit 2 worth 4 units, bit 1 worth 2 units and bit 0 worth 1 unit. One mid unit is worth 8 units and one upper unit is worth 128 units.
- R5: Each complement control is the bitwise inverse of its true control on every cycle, including reset and sleep.
- R6: A code present at the rising edge k appears on the controls right after edge k+1, a latency of two edges.
- R7: When awake, 128 × popcount(up_on_o) + 8 × popcount(mid_on_o) + lsb_on_o equals the code captured two edges earlier. The same weighted sum taken over the complement controls equals 4095 minus that code.
- R8: When sleep_i is high at a rising edge, all true controls are 0 and all complement controls are all ones after that edge. When sleep_i is low again, the decode of the held code returns after the next edge.
- R9: Code 4095 turns every true control on and every complement control off. Code 0 turns every true control off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Parks the array in its idle state |
| code_i | input | 12 | Unsigned sample code |
| up_on_o | output | 31 | Upper units steered to node A |
| up_off_o | output | 31 | Upper units steered to node B |
| mid_on_o | output | 15 | Middle units steered to node A |
| mid_off_o | output | 15 | Middle units steered to node B |
| lsb_on_o | output | 3 | Binary LSB switches to node A |
| lsb_off_o | output | 3 | Binary LSB switches to node B |

## Verification
On every clock cycle the assertions check the thermometer shape of both unary vectors and that each complement register is the inverse of its true register. They also check that the weighted A-side and B-side totals match the code captured two edges earlier, and that a sampled sleep forces the idle state. The bench sweeps all 4096 codes and compares each control vector with values computed from the code by arithmetic. Only the bench scenarios show the exact two-edge timing against a code change, the return from sleep, and the idle state during a reset asserted in the middle of a run.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;
  localparam int unsigned UP_W  = 5;
  localparam int unsigned MID_W = 4;
  localparam int unsigned LSB_W = 3;

  function automatic int unsigned therm_len(input int unsigned w);
    return (1 << w) - 1;
  endfunction
endpackage

// File: rtl/therm_dec.sv
module therm_dec #(
  parameter int unsigned IN_W  = 4,
  parameter int unsigned OUT_N = (1 << IN_W) - 1
) (
  input  logic [IN_W-1:0]  bin_i,
  output logic [OUT_N-1:0] therm_o
);
  // bit k is set when the field value exceeds k: fills from bit 0 upward
  for (genvar k = 0; k < OUT_N; k++) begin : g_bit
    assign therm_o[k] = (bin_i > IN_W'(k));
  end
endmodule

// File: rtl/code_splitter.sv
module code_splitter #(
  parameter int unsigned UP_W   = 5,
  parameter int unsigned MID_W  = 4,
  parameter int unsigned LSB_W  = 3,
  localparam int unsigned CODE_W = UP_W + MID_W + LSB_W,
  localparam int unsigned UP_N   = (1 << UP_W) - 1,
  localparam int unsigned MID_N  = (1 << MID_W) - 1
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [UP_N-1:0]   up_o,
  output logic [MID_N-1:0]  mid_o,
  output logic [LSB_W-1:0]  lsb_o
);
  logic [UP_W-1:0]  up_fld;
  logic [MID_W-1:0] mid_fld;

  assign up_fld  = code_i[CODE_W-1 -: UP_W];
  assign mid_fld = code_i[LSB_W +: MID_W];
  assign lsb_o   = code_i[LSB_W-1:0];

  therm_dec #(.IN_W(UP_W))  u_up  (.bin_i(up_fld),  .therm_o(up_o));
  therm_dec #(.IN_W(MID_W)) u_mid (.bin_i(mid_fld), .therm_o(mid_o));
endmodule

// File: rtl/pair_reg.sv
module pair_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         idle_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] on_o,
  output logic [W-1:0] off_o
);
  // true and complement held in separate flops so both edges of a switch pair match
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_o  <= '0;
      off_o <= '1;
    end else if (idle_i) begin
      on_o  <= '0;
      off_o <= '1;
    end else begin
      on_o  <= d_i;
      off_o <= ~d_i;
    end
  end
endmodule

// File: rtl/seg_dac_decoder.sv
module seg_dac_decoder
  import seg_dac_pkg::*;
#(
  parameter int unsigned UP_BITS  = UP_W,
  parameter int unsigned MID_BITS = MID_W,
  parameter int unsigned LSB_BITS = LSB_W,
  localparam int unsigned CODE_W = UP_BITS + MID_BITS + LSB_BITS,
  localparam int unsigned UP_N   = (1 << UP_BITS) - 1,
  localparam int unsigned MID_N  = (1 << MID_BITS) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [UP_N-1:0]   up_on_o,
  output logic [UP_N-1:0]   up_off_o,
  output logic [MID_N-1:0]  mid_on_o,
  output logic [MID_N-1:0]  mid_off_o,
  output logic [LSB_BITS-1:0] lsb_on_o,
  output logic [LSB_BITS-1:0] lsb_off_o
);
  logic [CODE_W-1:0]   code_q;
  logic [UP_N-1:0]     up_d;
  logic [MID_N-1:0]    mid_d;
  logic [LSB_BITS-1:0] lsb_d;

  // stage 1: input capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= '0;
    else         code_q <= code_i;
  end

  code_splitter #(.UP_W(UP_BITS), .MID_W(MID_BITS), .LSB_W(LSB_BITS)) u_split (
    .code_i(code_q), .up_o(up_d), .mid_o(mid_d), .lsb_o(lsb_d)
  );

  // stage 2: all switch pairs updated on one edge
  pair_reg #(.W(UP_N)) u_up_reg (
    .clk_i, .rst_ni, .idle_i(sleep_i), .d_i(up_d), .on_o(up_on_o), .off_o(up_off_o)
  );
  pair_reg #(.W(MID_N)) u_mid_reg (
    .clk_i, .rst_ni, .idle_i(sleep_i), .d_i(mid_d), .on_o(mid_on_o), .off_o(mid_off_o)
  );
  pair_reg #(.W(LSB_BITS)) u_lsb_reg (
    .clk_i, .rst_ni, .idle_i(sleep_i), .d_i(lsb_d), .on_o(lsb_on_o), .off_o(lsb_off_o)
  );
endmodule

// File: rtl/seg_dac_checker.sv
module seg_dac_checker #(
  parameter int unsigned UP_BITS  = 5,
  parameter int unsigned MID_BITS = 4,
  parameter int unsigned LSB_BITS = 3,
  localparam int unsigned CODE_W = UP_BITS + MID_BITS + LSB_BITS,
  localparam int unsigned UP_N   = (1 << UP_BITS) - 1,
  localparam int unsigned MID_N  = (1 << MID_BITS) - 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                sleep_i,
  input logic [CODE_W-1:0]   code_i,
  input logic [UP_N-1:0]     up_on_o,
  input logic [UP_N-1:0]     up_off_o,
  input logic [MID_N-1:0]    mid_on_o,
  input logic [MID_N-1:0]    mid_off_o,
  input logic [LSB_BITS-1:0] lsb_on_o,
  input logic [LSB_BITS-1:0] lsb_off_o
);
  logic [1:0] since_rst;
  int w_on, w_off;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  assign w_on  = ($countones(up_on_o) << (MID_BITS + LSB_BITS))
               + ($countones(mid_on_o) << LSB_BITS) + int'(lsb_on_o);
  assign w_off = ($countones(up_off_o) << (MID_BITS + LSB_BITS))
               + ($countones(mid_off_o) << LSB_BITS) + int'(lsb_off_o);

  p_up_shape_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((up_on_o & (up_on_o + 1'b1)) == '0));
  p_mid_shape_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mid_on_o & (mid_on_o + 1'b1)) == '0));
  p_compl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_off_o == ~up_on_o) && (mid_off_o == ~mid_on_o) && (lsb_off_o == ~lsb_on_o));
  p_sum_a_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd2 && !$past(sleep_i)) |-> (w_on == int'($past(code_i, 2))));
  p_sum_b_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 2'd2 && !$past(sleep_i)) |->
      (w_off == ((1 << CODE_W) - 1) - int'($past(code_i, 2))));
  p_sleep_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> (up_on_o == '0 && mid_on_o == '0 && lsb_on_o == '0));
endmodule

bind seg_dac_decoder seg_dac_checker #(
  .UP_BITS(UP_BITS), .MID_BITS(MID_BITS), .LSB_BITS(LSB_BITS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sleep_i(sleep_i), .code_i(code_i),
  .up_on_o(up_on_o), .up_off_o(up_off_o), .mid_on_o(mid_on_o),
  .mid_off_o(mid_off_o), .lsb_on_o(lsb_on_o), .lsb_off_o(lsb_off_o)
);

// File: tb/tb_seg_dac_decoder.sv
module tb_seg_dac_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep = 1'b0;
  logic [11:0] code = '0;
  logic [30:0] up_on, up_off;
  logic [14:0] mid_on, mid_off;
  logic [2:0]  lsb_on, lsb_off;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seg_dac_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .sleep_i(sleep), .code_i(code),
    .up_on_o(up_on), .up_off_o(up_off), .mid_on_o(mid_on), .mid_off_o(mid_off),
    .lsb_on_o(lsb_on), .lsb_off_o(lsb_off)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(up_on == '0 && mid_on == '0 && lsb_on == '0, req,
        longint'({up_on, mid_on, lsb_on}), 0);
    chk(up_off == '1 && mid_off == '1 && lsb_off == '1, req,
        longint'({up_off, mid_off, lsb_off}), 49'h1_ffff_ffff_ffff);
  endtask

  task automatic chk_code(input int c);
    logic [30:0] e_up;
    logic [14:0] e_mid;
    int w_a, w_b;
    e_up  = 31'((64'd1 << (c >> 7)) - 64'd1);
    e_mid = 15'((32'd1 << ((c >> 3) & 15)) - 32'd1);
    chk(up_on == e_up, "R2", longint'(up_on), longint'(e_up));
    chk(mid_on == e_mid, "R3", longint'(mid_on), longint'(e_mid));
    chk(int'(lsb_on) == (c & 7), "R4", longint'(lsb_on), longint'(c & 7));
    chk(up_off == ~up_on && mid_off == ~mid_on && lsb_off == ~lsb_on, "R5",
        longint'({up_off, mid_off, lsb_off}), longint'({~up_on, ~mid_on, ~lsb_on}));
    w_a = 128 * $countones(up_on) + 8 * $countones(mid_on) + int'(lsb_on);
    w_b = 128 * $countones(up_off) + 8 * $countones(mid_off) + int'(lsb_off);
    chk(w_a == c, "R7", w_a, c);
    chk(w_b == 4095 - c, "R7", w_b, 4095 - c);
  endtask

  task automatic apply(input int c);
    @(negedge clk); code = 12'(c);
    @(posedge clk); @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1");
    rst_n = 1'b1;

    for (int c = 0; c < 4096; c++) begin
      apply(c);
      chk_code(c);
    end

    // R9 extremes
    apply(0);
    chk(up_on == '0 && mid_on == '0 && lsb_on == '0, "R9", longint'(up_on), 0);
    apply(4095);
    chk(up_on == '1 && mid_on == '1 && lsb_on == '1 && up_off == '0 && mid_off == '0 && lsb_off == '0,
        "R9", longint'({up_on, mid_on, lsb_on}), longint'(49'h1_ffff_ffff_ffff));

    // R6 latency
    apply(100);
    code = 12'd2000;
    @(posedge clk); @(negedge clk);
    chk(int'(lsb_on) == (100 & 7) && up_on == 31'h0, "R6", longint'({up_on, lsb_on}), 100 & 7);
    @(posedge clk); @(negedge clk);
    chk_code(2000);

    // R8 sleep and wake
    apply(4095);
    sleep = 1'b1;
    @(posedge clk); @(negedge clk);
    chk_idle("R8");
    code = 12'd1234;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_idle("R8");
    sleep = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(128 * $countones(up_on) + 8 * $countones(mid_on) + int'(lsb_on) == 1234, "R8",
        longint'(128 * $countones(up_on) + 8 * $countones(mid_on) + int'(lsb_on)), 1234);

    // R1 asynchronous reset mid-run
    apply(3000);
    #1 rst_n = 1'b0;
    #1 chk_idle("R1");
    @(negedge clk); rst_n = 1'b1;
    apply(777);
    chk_code(777);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule